// File: doc/BRIEF.md
# Secure-Grouped Interrupt Acknowledge Unit

This block is the acknowledge side of a single-CPU interrupt controller interface. It holds a pending bit, an active bit, an 8-bit priority and a group bit for every interrupt ID. From all pending interrupts it picks the most urgent one. A read of the acknowledge offset then either takes that interrupt or returns a spurious code. The result depends on three things: whether the requester is secure, which group the interrupt is in, and whether its priority beats the one currently running.

A successful acknowledge does four things on the clock edge that registers the read response. It moves the interrupt from pending to active. It lowers the running priority value to that interrupt's priority. It makes the interrupt the running one. It stores the ID that was running before into that interrupt's last-active slot, so that a later completion can restore it. End-of-interrupt handling is outside this block, so the running priority only ever drops until reset.

Top module: `irq_ack_unit`

## Requirements
- R1: An acknowledge read (offset 0x0C) with no interrupt pending returns 1023.
- R2: A non-secure acknowledge read whose best pending interrupt is in group 0 returns 1022. Pending, active, running ID and running priority stay unchanged.
- R3: A secure acknowledge read whose best pending interrupt is in group 1 returns 1022 and changes nothing when `ack_ctl` is 0. When `ack_ctl` is 1 the read may take the interrupt.
- R4: When the best pending interrupt is in an allowed group but its priority value is greater than or equal to the running priority, the read returns 1023 and nothing is activated.
- R5: The best pending interrupt is the one with the numerically lowest priority value. On equal values the lowest ID wins. The group is checked only after this choice is made.
- R6: A successful acknowledge returns the ID in `rd_data` one cycle after `rd_en`. On that same edge it clears the pending bit, sets the active bit, sets `run_id` to the ID and sets `run_prio` to the interrupt's priority.
- R7: On a successful acknowledge, the interrupt's last-active slot receives the previously running ID. `nest_prev_id` shows the last-active slot of the running interrupt, or 1023 while idle.
- R8: A read at offset 0x14 returns `run_prio` zero-extended. Any other offset returns 0. After reset: `rd_data` is 0, `run_prio` is 0xFF, `run_id` is 1023, and all pending and active bits are clear.
- R9: `irq_out` is high exactly when some interrupt is pending and the best one's priority value is below `run_prio`.
- R10: A `cfg_we` write sets the priority and group of `cfg_id`. A bit of `pend_set` marks that ID pending, and this wins over an acknowledge of the same ID in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_set | input | NUM_IRQ | One-cycle pulses that mark IDs pending |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_id | input | IDX_W | ID being configured |
| cfg_prio | input | PRIO_W | Priority value to store |
| cfg_group | input | 1 | Group to store (0 or 1) |
| ack_ctl | input | 1 | Lets secure reads take group 1 interrupts |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Byte offset of the read |
| rd_secure | input | 1 | Read comes from the secure state |
| rd_data | output | 32 | Registered read response |
| irq_out | output | 1 | Interrupt request to the CPU |
| pend_q | output | NUM_IRQ | Pending bits |
| act_q | output | NUM_IRQ | Active bits |
| run_prio | output | PRIO_W | Running priority |
| run_id | output | 10 | Running interrupt ID, 1023 when idle |
| nest_prev_id | output | 10 | Last-active slot of the running interrupt |

## Verification
The bench builds the block with 16 interrupt IDs instead of 64. Priorities are drawn from only eight levels plus 0xFF. This makes equal-priority ties and repeated hits on the same ID common, so the lowest-ID tie-break and the case where a pend pulse and an acknowledge hit the same ID are both reached often. Random resets keep the running priority from sinking to zero for good, so the refusals caused by wrong group and by too-low priority both keep happening throughout the run.

// File: rtl/irq_ack_unit.sv
module irq_ack_unit #(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8,
  localparam int IDX_W  = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] pend_set,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_id,
  input  logic [PRIO_W-1:0]  cfg_prio,
  input  logic               cfg_group,
  input  logic               ack_ctl,
  input  logic               rd_en,
  input  logic [7:0]         rd_addr,
  input  logic               rd_secure,
  output logic [31:0]        rd_data,
  output logic               irq_out,
  output logic [NUM_IRQ-1:0] pend_q,
  output logic [NUM_IRQ-1:0] act_q,
  output logic [PRIO_W-1:0]  run_prio,
  output logic [9:0]         run_id,
  output logic [9:0]         nest_prev_id
);
  localparam logic [7:0] OFS_ACK = 8'h0C;
  localparam logic [7:0] OFS_RPR = 8'h14;
  localparam logic [9:0] ID_NONE = 10'd1023;
  localparam logic [9:0] ID_WRONG_GRP = 10'd1022;

  logic [PRIO_W-1:0] prio_q [NUM_IRQ];
  logic [9:0]        last_q [NUM_IRQ];
  logic [NUM_IRQ-1:0] grp_q;

  logic              best_ok;
  logic [IDX_W-1:0]  best_id;
  logic [PRIO_W-1:0] best_pr;

  always_comb begin
    best_ok = 1'b0;
    best_id = '0;
    best_pr = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (pend_q[i] && (!best_ok || prio_q[i] < best_pr)) begin
        best_ok = 1'b1;
        best_id = IDX_W'(i);
        best_pr = prio_q[i];
      end
    end
  end

  logic       group_ok, beats, do_ack;
  logic [9:0] ack_code;
  logic [NUM_IRQ-1:0] ack_clr;

  assign group_ok = grp_q[best_id] ? (!rd_secure || ack_ctl) : rd_secure;
  assign beats    = best_pr < run_prio;
  assign do_ack   = rd_en && rd_addr == OFS_ACK && best_ok && group_ok && beats;
  assign ack_code = !best_ok  ? ID_NONE :
                    !group_ok ? ID_WRONG_GRP :
                    !beats    ? ID_NONE : 10'(best_id);
  assign ack_clr  = do_ack ? (NUM_IRQ'(1) << best_id) : '0;
  assign irq_out  = best_ok && beats;
  assign nest_prev_id = (run_id == ID_NONE) ? ID_NONE : last_q[run_id[IDX_W-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      act_q    <= '0;
      grp_q    <= '0;
      run_prio <= '1;
      run_id   <= ID_NONE;
      rd_data  <= '0;
      for (int i = 0; i < NUM_IRQ; i++) begin
        prio_q[i] <= '0;
        last_q[i] <= ID_NONE;
      end
    end else begin
      pend_q <= (pend_q & ~ack_clr) | pend_set;
      if (cfg_we) begin
        prio_q[cfg_id] <= cfg_prio;
        grp_q[cfg_id]  <= cfg_group;
      end
      if (rd_en) begin
        if (rd_addr == OFS_ACK)      rd_data <= 32'(ack_code);
        else if (rd_addr == OFS_RPR) rd_data <= 32'(run_prio);
        else                         rd_data <= '0;
      end
      if (do_ack) begin
        act_q[best_id]  <= 1'b1;
        last_q[best_id] <= run_id;
        run_id          <= 10'(best_id);
        run_prio        <= best_pr;
      end
    end
  end
endmodule

// File: rtl/irq_ack_unit_chk.sv
module irq_ack_unit_chk #(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_en,
  input logic [7:0]         rd_addr,
  input logic [31:0]        rd_data,
  input logic               irq_out,
  input logic [NUM_IRQ-1:0] pend_q,
  input logic [NUM_IRQ-1:0] act_q,
  input logic [PRIO_W-1:0]  run_prio,
  input logic [9:0]         run_id,
  input logic [9:0]         nest_prev_id
);
  AST_IDLE_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_addr == 8'h0C && pend_q == '0 |=> rd_data == 32'd1023); // R1
  AST_REFUSE_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_addr == 8'h0C |=> rd_data < NUM_IRQ || ($stable(act_q) && $stable(run_prio) && $stable(run_id))); // R2
  AST_ACK_ACTIVATES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_addr == 8'h0C |=> (rd_data < NUM_IRQ) == ($countones(act_q) == $countones($past(act_q)) + 1)); // R6
  AST_ACK_RAISES_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_addr == 8'h0C |=> rd_data >= NUM_IRQ || run_prio < $past(run_prio)); // R4
  AST_NEST_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_addr == 8'h0C |=> rd_data >= NUM_IRQ || nest_prev_id == $past(run_id)); // R7
  AST_NO_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q == '0 |-> !irq_out); // R9
endmodule

bind irq_ack_unit irq_ack_unit_chk #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .irq_out(irq_out), .pend_q(pend_q), .act_q(act_q), .run_prio(run_prio),
  .run_id(run_id), .nest_prev_id(nest_prev_id)
);

// File: tb/irq_ack_unit_tb_top.sv
module irq_ack_unit_tb_top;
  localparam int N = 16;
  localparam int IW = $clog2(N);

  logic clk = 0, rst_n = 0;
  logic [N-1:0] pend_set = '0;
  logic cfg_we = 0, cfg_group = 0, ack_ctl = 0, rd_en = 0, rd_secure = 0;
  logic [IW-1:0] cfg_id = '0;
  logic [7:0] cfg_prio = '0, rd_addr = '0;
  logic [31:0] rd_data;
  logic irq_out;
  logic [N-1:0] pend_q, act_q;
  logic [7:0] run_prio;
  logic [9:0] run_id, nest_prev_id;

  irq_ack_unit #(.NUM_IRQ(N), .PRIO_W(8)) dut_i (.*);

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  logic [7:0] m_prio [N];
  logic [9:0] m_last [N];
  logic [N-1:0] m_pend, m_act, m_grp;
  logic [9:0] m_rid;
  logic [7:0] m_rpr;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int best_id();
    int b = -1;
    for (int i = 0; i < N; i++)
      if (m_pend[i] && (b < 0 || m_prio[i] < m_prio[b])) b = i;
    return b;
  endfunction

  function automatic logic [9:0] nest_exp();
    return (m_rid == 10'd1023) ? 10'd1023 : m_last[m_rid[IW-1:0]];
  endfunction

  task automatic check_state();
    int b = best_id();
    check("R9 irq_out", 32'(irq_out), 32'(b >= 0 && m_prio[b] < m_rpr));
    check("R10 pend_q", 32'(pend_q), 32'(m_pend));
    check("R6 act_q", 32'(act_q), 32'(m_act));
    check("R6 run_prio", 32'(run_prio), 32'(m_rpr));
    check("R6 run_id", 32'(run_id), 32'(m_rid));
    check("R7 nest_prev_id", 32'(nest_prev_id), 32'(nest_exp()));
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_pend = '0; m_act = '0; m_grp = '0; m_rid = 10'd1023; m_rpr = 8'hFF;
    for (int i = 0; i < N; i++) begin m_prio[i] = '0; m_last[i] = 10'd1023; end
    check("R8 reset rd_data", rd_data, 32'd0);
    check_state();
  endtask

  task automatic step(logic [N-1:0] ps, logic we, int id, logic [7:0] pr, logic g,
                      logic actl, logic re, logic [7:0] ad, logic sec);
    int b = best_id();
    logic [31:0] exp = 0;
    string tag = "R8";
    logic ok = 0;
    pend_set = ps; cfg_we = we; cfg_id = IW'(id); cfg_prio = pr; cfg_group = g;
    ack_ctl = actl; rd_en = re; rd_addr = ad; rd_secure = sec;
    if (re && ad == 8'h0C) begin
      if (b < 0) begin exp = 1023; tag = "R1"; end
      else if (m_grp[b] ? (sec && !actl) : !sec) begin exp = 1022; tag = sec ? "R3" : "R2"; end
      else if (m_prio[b] >= m_rpr) begin exp = 1023; tag = "R4"; end
      else begin exp = 32'(b); tag = "R5 R6"; ok = 1; end
    end else if (re && ad == 8'h14) exp = 32'(m_rpr);
    @(posedge clk);
    @(negedge clk);
    if (ok) begin
      m_pend[b] = 1'b0; m_act[b] = 1'b1; m_last[b] = m_rid;
      m_rid = 10'(b); m_rpr = m_prio[b];
    end
    m_pend = m_pend | ps;
    if (we) begin m_prio[id] = pr; m_grp[id] = g; end
    pend_set = '0; cfg_we = 0; rd_en = 0;
    if (re) check(tag, rd_data, exp);
    check_state();
  endtask

  task automatic cfg(int id, logic [7:0] pr, logic g);
    step('0, 1, id, pr, g, 0, 0, 8'h00, 0);
  endtask

  task automatic rd(logic [7:0] ad, logic sec, logic actl);
    step('0, 0, 0, 8'h00, 0, actl, 1, ad, sec);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    do_reset();
    rd(8'h0C, 1, 0);                                   // R1 idle
    cfg(3, 8'h40, 0);
    step(N'(1) << 3, 0, 0, 0, 0, 0, 0, 0, 0);
    rd(8'h0C, 0, 1);                                   // R2 group 0, non-secure
    rd(8'h0C, 1, 0);                                   // R6 secure takes it
    cfg(5, 8'h20, 1);
    cfg(7, 8'h20, 1);
    step((N'(1) << 5) | (N'(1) << 7), 0, 0, 0, 0, 0, 0, 0, 0);
    rd(8'h0C, 1, 0);                                   // R3 blocked
    rd(8'h0C, 1, 1);                                   // R3 allowed, R5 tie -> 5, R7 nest 3
    rd(8'h0C, 0, 0);                                   // R4 equal priority -> 1023
    rd(8'h14, 0, 0);                                   // R8 running priority
    rd(8'h10, 1, 0);                                   // R8 other offset
    cfg(9, 8'hFF, 0);
    step(N'(1) << 9, 0, 0, 0, 0, 0, 1, 8'h0C, 1);      // R10 pend + read same cycle
    do_reset();
    cfg(2, 8'h10, 1);
    step(N'(1) << 2, 0, 0, 0, 0, 0, 0, 0, 0);
    step(N'(1) << 2, 0, 0, 0, 0, 0, 1, 8'h0C, 0);      // R10 pend wins over clear
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] ps = '0;
      logic [7:0] pr = ($urandom % 10 == 0) ? 8'hFF : 8'(($urandom % 8) * 32);
      logic [7:0] ad = ($urandom % 6 == 0) ? 8'h14 : ($urandom % 10 == 0) ? 8'h08 : 8'h0C;
      if (k % 60 == 59) do_reset();
      if ($urandom % 3 == 0) ps = N'(1) << ($urandom % N);
      if ($urandom % 8 == 0) ps = ps | N'($urandom);
      step(ps, $urandom % 3 == 0, int'($urandom % N), pr, 1'($urandom),
           1'($urandom), $urandom % 2 == 0, ad, 1'($urandom));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule